// File: doc/BRIEF.md
# Processor Status Register Unit

This block holds the 16-bit status word of a small CPU core. The upper byte carries a three-bit interrupt level mask and a five-bit register bank pointer. The lower byte carries the condition flags: interrupt enable, stack select, sticky, negative, zero, overflow and carry. Software can load the whole word in one write. The ALU can update the five arithmetic flags one at a time through per-flag enables. Accepting an interrupt forces the stack-select bit to the system stack.

The unit drives two things from the stored word. It picks either the user or the system stack pointer value, and it gates a vector of hardware interrupt requests with the interrupt-enable bit. Software interrupt requests are not gated. Instruction decode, the ALU datapath and interrupt priority arbitration are outside the block.

Top module: `psr_unit`

## Requirements
- R1: Bit layout of `psr_o`: bits 15:13 are the level mask, bits 12:8 are the bank pointer, and bit 6 is interrupt enable I. Bit 5 is stack select S, bit 4 is sticky T, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. When `sw_we_i` is high at a clock edge, `psr_o` takes `sw_data_i` (bit 7 excepted) after that edge.
- R2: While `rst_n` is low, I reads 0, S reads 1, and the level mask and bank pointer read 0. The T, N, Z, V and C bits are undefined after reset.
- R3: `irq_accept_i` high at a clock edge sets S to 1 after that edge. The other bits are left as the other inputs make them.
- R4: When `irq_accept_i` and `sw_we_i` are both high at the same edge, S ends up 1 and every other field takes the written value.
- R5: When `sw_we_i` and any `flag_we_i` bit are high at the same edge, the flags take the software value.
- R6: `flag_we_i` bit 4 enables T, bit 3 N, bit 2 Z, bit 1 V and bit 0 C. A flag whose enable is low keeps its value.
- R7: An enabled N takes the MSB of `alu_result_i`. An enabled Z becomes 1 exactly when `alu_result_i` is all zeros.
- R8: An enabled V takes `alu_ovf_i`, an enabled C takes `alu_carry_i` and an enabled T takes `alu_sticky_i`.
- R9: Bit 7 of `psr_o` always reads 0, whatever is written to it.
- R10: `stack_sys_o` equals S. `sp_o` equals `usp_i` when S is 0 and `ssp_i` when S is 1, with no added cycle.
- R11: `irq_en_o` equals I. `irq_pend_o` is high when any `sw_irq_req_i` line is high, or when any `hw_irq_req_i` line is high and I is 1. There is no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Software write strobe for the full word |
| sw_data_i | input | 16 | Software write data |
| irq_accept_i | input | 1 | Interrupt accepted, forces S |
| flag_we_i | input | 5 | Per-flag enables {T,N,Z,V,C} |
| alu_result_i | input | RES_W | ALU result, used for N and Z |
| alu_carry_i | input | 1 | Carry or borrow out of the MSB |
| alu_ovf_i | input | 1 | Signed overflow |
| alu_sticky_i | input | 1 | Ones shifted out past carry |
| usp_i | input | SP_W | User stack pointer value |
| ssp_i | input | SP_W | System stack pointer value |
| hw_irq_req_i | input | NHW | Hardware interrupt requests |
| sw_irq_req_i | input | NSW | Software interrupt requests |
| psr_o | output | 16 | Status word |
| sp_o | output | SP_W | Active stack pointer |
| stack_sys_o | output | 1 | System stack selected |
| irq_en_o | output | 1 | Interrupt enable bit |
| irq_pend_o | output | 1 | Gated interrupt pending |

## Verification
Full-word writes use all-ones, all-zeros and alternating patterns, with bit 7 set, so a swapped or stuck field shows up as a mismatch in a known position. ALU updates are tried one enable at a time and with all five enables together, using zero, MSB-set and mixed results. This separates the N and Z derivation from the V, C and T pass-through, and catches a disable that is not honoured. Coincident cases (write with ALU update, write with interrupt accept) confirm the priority order. The stack mux and the interrupt gate are driven with distinct pointer values and with hardware-only, software-only and both request patterns, under I at 0 and at 1.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W  = 16;
  localparam int NFLAG  = 5;
  localparam int FL_T   = 4;
  localparam int FL_N   = 3;
  localparam int FL_Z   = 2;
  localparam int FL_V   = 1;
  localparam int FL_C   = 0;

  typedef struct packed {
    logic [2:0] ilm;
    logic [4:0] bank;
    logic       rsvd;
    logic       ie;
    logic       ss;
    logic       t;
    logic       n;
    logic       z;
    logic       v;
    logic       c;
  } psr_t;

  typedef logic [NFLAG-1:0] flags_t;

  localparam psr_t PSR_RST = '{ilm: 3'd0, bank: 5'd0, rsvd: 1'b0, ie: 1'b0,
                               ss: 1'b1, t: 1'b0, n: 1'b0, z: 1'b0,
                               v: 1'b0, c: 1'b0};
endpackage

// File: rtl/psr_flag_gen.sv
module psr_flag_gen
  import psr_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] result_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             sticky_i,
  output flags_t           flags_o
);
  localparam int MSB = RES_W - 1;

  always_comb begin
    flags_o       = '0;
    flags_o[FL_T] = sticky_i;
    flags_o[FL_N] = result_i[MSB];
    flags_o[FL_Z] = (result_i == '0);
    flags_o[FL_V] = ovf_i;
    flags_o[FL_C] = carry_i;
  end
endmodule

// File: rtl/psr_next.sv
module psr_next
  import psr_pkg::*;
(
  input  psr_t             cur_i,
  input  logic             sw_we_i,
  input  logic [PSR_W-1:0] sw_data_i,
  input  logic             irq_accept_i,
  input  flags_t           flag_we_i,
  input  flags_t           alu_flags_i,
  output psr_t             nxt_o,
  output logic             en_o
);
  flags_t cur_fl;
  flags_t mrg_fl;

  assign cur_fl = {cur_i.t, cur_i.n, cur_i.z, cur_i.v, cur_i.c};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign mrg_fl[g] = flag_we_i[g] ? alu_flags_i[g] : cur_fl[g];
  end

  always_comb begin
    nxt_o = cur_i;
    if (sw_we_i) begin
      nxt_o = psr_t'(sw_data_i);
    end else begin
      {nxt_o.t, nxt_o.n, nxt_o.z, nxt_o.v, nxt_o.c} = mrg_fl;
    end
    if (irq_accept_i) nxt_o.ss = 1'b1;
    nxt_o.rsvd = 1'b0;
  end

  assign en_o = sw_we_i | irq_accept_i | (|flag_we_i);
endmodule

// File: rtl/psr_sp_mux.sv
module psr_sp_mux #(
  parameter int SP_W = 16
) (
  input  logic            sel_sys_i,
  input  logic [SP_W-1:0] usp_i,
  input  logic [SP_W-1:0] ssp_i,
  output logic [SP_W-1:0] sp_o
);
  always_comb begin
    sp_o = sel_sys_i ? ssp_i : usp_i;
  end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int NHW = 4,
  parameter int NSW = 2
) (
  input  logic           ie_i,
  input  logic [NHW-1:0] hw_req_i,
  input  logic [NSW-1:0] sw_req_i,
  output logic           pend_o
);
  logic [NHW-1:0] hw_gated;

  for (genvar g = 0; g < NHW; g++) begin : g_mask
    assign hw_gated[g] = hw_req_i[g] & ie_i;
  end

  assign pend_o = (|hw_gated) | (|sw_req_i);
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int SP_W  = 16,
  parameter int NHW   = 4,
  parameter int NSW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we_i,
  input  logic [15:0]      sw_data_i,
  input  logic             irq_accept_i,
  input  logic [4:0]       flag_we_i,
  input  logic [RES_W-1:0] alu_result_i,
  input  logic             alu_carry_i,
  input  logic             alu_ovf_i,
  input  logic             alu_sticky_i,
  input  logic [SP_W-1:0]  usp_i,
  input  logic [SP_W-1:0]  ssp_i,
  input  logic [NHW-1:0]   hw_irq_req_i,
  input  logic [NSW-1:0]   sw_irq_req_i,
  output logic [15:0]      psr_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             stack_sys_o,
  output logic             irq_en_o,
  output logic             irq_pend_o
);
  psr_t   psr_q;
  psr_t   psr_d;
  logic   psr_en;
  flags_t alu_flags;

  psr_flag_gen #(.RES_W(RES_W)) u_flag_gen (
    .result_i (alu_result_i),
    .carry_i  (alu_carry_i),
    .ovf_i    (alu_ovf_i),
    .sticky_i (alu_sticky_i),
    .flags_o  (alu_flags)
  );

  psr_next u_next (
    .cur_i        (psr_q),
    .sw_we_i      (sw_we_i),
    .sw_data_i    (sw_data_i),
    .irq_accept_i (irq_accept_i),
    .flag_we_i    (flag_we_i),
    .alu_flags_i  (alu_flags),
    .nxt_o        (psr_d),
    .en_o         (psr_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q <= PSR_RST;
    end else if (psr_en) begin
      psr_q <= psr_d;
    end
  end

  psr_sp_mux #(.SP_W(SP_W)) u_sp_mux (
    .sel_sys_i (psr_q.ss),
    .usp_i     (usp_i),
    .ssp_i     (ssp_i),
    .sp_o      (sp_o)
  );

  psr_irq_gate #(.NHW(NHW), .NSW(NSW)) u_irq_gate (
    .ie_i     (psr_q.ie),
    .hw_req_i (hw_irq_req_i),
    .sw_req_i (sw_irq_req_i),
    .pend_o   (irq_pend_o)
  );

  assign psr_o       = psr_q;
  assign stack_sys_o = psr_q.ss;
  assign irq_en_o    = psr_q.ie;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk #(
  parameter int RES_W = 16,
  parameter int SP_W  = 16,
  parameter int NHW   = 4,
  parameter int NSW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_we_i,
  input logic [15:0]      sw_data_i,
  input logic             irq_accept_i,
  input logic [4:0]       flag_we_i,
  input logic [RES_W-1:0] alu_result_i,
  input logic             alu_carry_i,
  input logic             alu_ovf_i,
  input logic             alu_sticky_i,
  input logic [SP_W-1:0]  usp_i,
  input logic [SP_W-1:0]  ssp_i,
  input logic [NHW-1:0]   hw_irq_req_i,
  input logic [NSW-1:0]   sw_irq_req_i,
  input logic [15:0]      psr_o,
  input logic [SP_W-1:0]  sp_o,
  input logic             stack_sys_o,
  input logic             irq_en_o,
  input logic             irq_pend_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_val_r2: assert (psr_o[6] == 1'b0 && psr_o[5] == 1'b1 && psr_o[15:8] == 8'h00);
    end
  end

  p_bit7_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psr_o[7] == 1'b0);

  p_irq_sets_s_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept_i |=> psr_o[5]);

  p_sw_beats_alu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we_i |=> psr_o[4:0] == $past(sw_data_i[4:0]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && !irq_accept_i && flag_we_i == 5'd0) |=> $stable(psr_o));

  p_n_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && flag_we_i[3]) |=> psr_o[3] == $past(alu_result_i[RES_W-1]));

  p_sp_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o == (stack_sys_o ? ssp_i : usp_i));

  p_sw_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_irq_req_i) |-> irq_pend_o);

  p_hw_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_o && sw_irq_req_i == '0) |-> !irq_pend_o);
endmodule

bind psr_unit psr_unit_chk #(.RES_W(RES_W), .SP_W(SP_W), .NHW(NHW), .NSW(NSW)) u_chk (.*);

// File: tb/psr_unit_tb_top.sv
module psr_unit_tb_top;
  localparam int RES_W = 16;
  localparam int SP_W  = 16;
  localparam int NHW   = 4;
  localparam int NSW   = 2;

  logic             clk;
  logic             rst_n;
  logic             sw_we;
  logic [15:0]      sw_data;
  logic             irq_acc;
  logic [4:0]       fwe;
  logic [RES_W-1:0] res;
  logic             cy, ov, st;
  logic [SP_W-1:0]  usp, ssp;
  logic [NHW-1:0]   hw;
  logic [NSW-1:0]   swi;
  logic [15:0]      psr;
  logic [SP_W-1:0]  sp;
  logic             ssel, ien, pend;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R2";

  logic [15:0] m_psr;
  logic [4:0]  m_known;

  psr_unit #(.RES_W(RES_W), .SP_W(SP_W), .NHW(NHW), .NSW(NSW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we), .sw_data_i(sw_data),
    .irq_accept_i(irq_acc), .flag_we_i(fwe), .alu_result_i(res),
    .alu_carry_i(cy), .alu_ovf_i(ov), .alu_sticky_i(st),
    .usp_i(usp), .ssp_i(ssp), .hw_irq_req_i(hw), .sw_irq_req_i(swi),
    .psr_o(psr), .sp_o(sp), .stack_sys_o(ssel), .irq_en_o(ien),
    .irq_pend_o(pend)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model: behaviour of the status word, flags tracked with a known mask
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psr   = 16'h0020;
      m_known = 5'b00000;
    end else begin
      logic [15:0] n;
      logic [4:0]  af;
      n  = m_psr;
      af = {st, res[RES_W-1], (res == 0), ov, cy};
      if (sw_we) begin
        n       = sw_data;
        m_known = 5'b11111;
      end else begin
        for (int i = 0; i < 5; i++) begin
          if (fwe[i]) begin
            n[i]       = af[i];
            m_known[i] = 1'b1;
          end
        end
      end
      if (irq_acc) n[5] = 1'b1;
      n[7]  = 1'b0;
      m_psr = n;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] mask;
    mask = {11'h7FF, m_known};
    chk("psr", {16'h0, psr & mask}, {16'h0, m_psr & mask});
    chk("sp", {{(32-SP_W){1'b0}}, sp}, {{(32-SP_W){1'b0}}, (m_psr[5] ? ssp : usp)});
    chk("stack_sel", {31'h0, ssel}, {31'h0, m_psr[5]});
    chk("irq", {30'h0, ien, pend},
        {30'h0, m_psr[6], ((|swi) | ((|hw) & m_psr[6]))});
  endtask

  task automatic idle();
    sw_we = 0; irq_acc = 0; fwe = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic swr(input logic [15:0] d);
    sw_we = 1; sw_data = d;
    tick();
  endtask

  task automatic alu(input logic [4:0] we, input logic [15:0] r,
                     input logic c, input logic v, input logic t);
    fwe = we; res = r; cy = c; ov = v; st = t;
    tick();
  endtask

  initial begin
    rst_n = 1'b1;
    idle();
    sw_data = 0; res = 0; cy = 0; ov = 0; st = 0;
    usp = 16'h1111; ssp = 16'h2222; hw = 0; swi = 0;
    #1 rst_n = 1'b0;
    // R2: reset state, S selects the system pointer (R10)
    cur_req = "R2";
    repeat (2) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    tick();

    // R1 and R9: full word loads, bit 7 never sticks
    cur_req = "R1";
    swr(16'hFFFF);
    swr(16'h0000);
    swr(16'hA55A);
    cur_req = "R9";
    swr(16'h0080);
    swr(16'h5AFF);

    // R3: interrupt accept with S clear
    cur_req = "R3";
    swr(16'h1240);
    irq_acc = 1; tick();
    tick();

    // R4: accept coinciding with a write that clears S
    cur_req = "R4";
    sw_we = 1; sw_data = 16'hE09F; irq_acc = 1; tick();

    // R5: software write beats an ALU update
    cur_req = "R5";
    sw_we = 1; sw_data = 16'h0005; fwe = 5'b11111; res = 16'h0000;
    cy = 0; ov = 1; st = 1; tick();

    // R6: single enables, others hold
    cur_req = "R6";
    swr(16'h001F);
    alu(5'b00001, 16'h0001, 0, 1, 0);
    alu(5'b00010, 16'h0001, 1, 0, 1);
    alu(5'b10000, 16'h8000, 1, 1, 0);
    alu(5'b00000, 16'h0000, 0, 0, 1);

    // R7: N and Z derivation
    cur_req = "R7";
    alu(5'b01100, 16'h0000, 0, 0, 0);
    alu(5'b01100, 16'h8000, 0, 0, 0);
    alu(5'b01100, 16'h0100, 0, 0, 0);
    alu(5'b01100, 16'hFFFF, 0, 0, 0);

    // R8: V, C, T pass-through with all enables
    cur_req = "R8";
    alu(5'b11111, 16'h7FFF, 1, 0, 1);
    alu(5'b11111, 16'h0000, 0, 1, 0);

    // R10: stack pointer mux both ways
    cur_req = "R10";
    usp = 16'hBEEF; ssp = 16'hCAFE;
    swr(16'h0000);
    usp = 16'h0123; tick();
    swr(16'h0020);
    ssp = 16'h4567; tick();

    // R11: interrupt gating under I clear and I set
    cur_req = "R11";
    swr(16'h0000);
    hw = 4'b0100; tick();
    hw = 0; swi = 2'b10; tick();
    swr(16'h0040);
    hw = 4'b0001; swi = 0; tick();
    hw = 4'b1111; swi = 2'b01; tick();
    hw = 0; swi = 0; tick();

    // R2: reset again mid-run
    cur_req = "R2";
    swr(16'hFF5F);
    rst_n = 1'b0;
    #1;
    compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule